// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a live calendar (seconds, minutes, hours, weekday, month, year, date) that a timekeeping counter elsewhere supplies, and compares it against two programmed alarm times. Only the fields marked as enabled take part in the comparison. The alarm fires when every enabled field is equal to its live counterpart. The weekday field is always excluded from the match.

Each field can be enabled in one of two ways, chosen by a strap input. In flag mode, the top bit of each alarm field register enables that field, and the comparison uses only the lower seven bits. In separate-enable mode, each alarm has its own enable register with one bit per field, and the comparison uses the full byte. Alarm events, two periodic tick pulses and two power-event pulses are collected in a sticky status register that clears when read. A mask register decides which status bits may pull the shared active-low interrupt line.

Top module: `rtc_alarm_top`

## Requirements
- R1: Alarm n (0 or 1) stores field i (0..6) at byte address 8*n+i. The field indices are 0 sec, 1 min, 2 hour, 3 weekday, 4 month, 5 year, 6 date. Alarm n has its enable register at 0x10+n, the status register is at 0x12 and the mask register is at 0x13. Every other address reads 0 and ignores writes. A write to the status register has no effect. Read data is registered: it is valid in the cycle after `regRd` and holds until the next read.
- R2: In flag mode (`sepEnMode`=0), bit 7 of an alarm field register enables that field. An enabled field matches when the live field equals the register's bits 6:0 with bit 7 taken as zero.
- R3: The weekday field (index 3) never takes part in the match, whatever its flag, enable bit or value.
- R4: In separate-enable mode (`sepEnMode`=1), bit i of the alarm's enable register enables field i, and an enabled field matches on all 8 bits. The value 0x77 arms every field except weekday.
- R5: An alarm with no enabled field never fires. This covers an enable register of zero, and also field flags that are all clear.
- R6: An alarm fires once, in the clock cycle in which its match condition becomes true. It does not fire again while the match holds. It fires again after the match goes false and then true again.
- R7: Status bit positions are: 0 alarm 0, 1 alarm 1, 2 `secTick`, 3 `minTick`, 4 `pwrEvtA`, 5 `pwrEvtB`. A source pulse or an alarm firing sets its bit at the next clock edge, and the bit stays set.
- R8: Reading the status register returns its current value and clears it. An event that arrives in the same cycle as the clearing read remains set.
- R9: Mask bit k (1 = masked) gates status bit k. The mask resets to 0x3F. `irqN` is low exactly when some status bit is set and its mask bit is clear. A masked source still sets its status bit.
- R10: After reset, all alarm field and enable registers and the status register are zero, read data is zero, and `irqN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sepEnMode | input | 1 | 0 = per-field flag enables, 1 = separate enable registers |
| calFields | input | 56 | Live calendar, field i in bits 8i+7:8i |
| secTick | input | 1 | One-second tick pulse |
| minTick | input | 1 | Sixty-second tick pulse |
| pwrEvtA | input | 1 | First power-event pulse |
| pwrEvtB | input | 1 | Second power-event pulse |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 5 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Registered read data |
| irqN | output | 1 | Shared active-low interrupt |

## Verification
The hardest situation to reach is a match condition that rises, holds for many cycles while unrelated fields and registers change, and then rises again. In that case the single-shot rule must be checked both ways: no repeat while the match holds, and a second event after it drops and returns. A plain sweep of random values seldom produces this, because all enabled fields have to line up. The stimulus therefore draws both the live calendar and the alarm values from a few small ranges, so that matches appear, persist and break often. Directed sequences also rearm an alarm while the calendar already matches, switch enable modes, and issue a clearing read in the same cycle as a new event.

// File: rtl/rtcAlarmPkg.sv
package rtcAlarmPkg;
  localparam int ALARMS    = 2;
  localparam int FIELDS    = 7;
  localparam int FW        = 8;
  localparam int AW        = 5;
  localparam int SRC_N     = ALARMS + 4;
  localparam int WDAY_IDX  = 3;
  localparam int ALM_IDX_W = (ALARMS > 1) ? $clog2(ALARMS) : 1;
  localparam int FLD_IDX_W = 3;
  localparam int HIGH_BASE = 1 << (AW - 1);
  localparam int STAT_OFF  = ALARMS;
  localparam int MASK_OFF  = ALARMS + 1;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_FIELD,
    RD_EN,
    RD_STAT,
    RD_MASK
  } rdSel_t;

  typedef struct packed {
    logic [ALARMS-1:0][FIELDS-1:0] fieldWe;
    logic [ALARMS-1:0]             enWe;
    logic                          maskWe;
    logic                          statusRd;
    logic                          rdLoad;
    rdSel_t                        rdSel;
    logic [ALM_IDX_W-1:0]          rdAlarm;
    logic [FLD_IDX_W-1:0]          rdField;
  } strobes_t;
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtcAlarmPkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sepMode,
  input  logic [FIELDS-1:0][FW-1:0]   almFields,
  input  logic [FW-1:0]               enReg,
  input  logic [FIELDS-1:0][FW-1:0]   cal,
  output logic                        fire
);
  logic [FIELDS-1:0] fieldEn;
  logic [FIELDS-1:0] fieldEq;
  logic              matchNow;
  logic              prevQ;

  for (genvar i = 0; i < FIELDS; i++) begin : g_fld
    if (i == WDAY_IDX) begin : g_wday
      assign fieldEn[i] = 1'b0;
      assign fieldEq[i] = 1'b1;
    end else begin : g_cmp
      logic [FW-1:0] flagVal;
      assign flagVal    = {1'b0, almFields[i][FW-2:0]};
      assign fieldEn[i] = sepMode ? enReg[i] : almFields[i][FW-1];
      assign fieldEq[i] = sepMode ? (almFields[i] == cal[i]) : (flagVal == cal[i]);
    end
  end

  assign matchNow = (|fieldEn) && (&(fieldEq | ~fieldEn));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= matchNow;
  end

  assign fire = matchNow & ~prevQ;

  // R6
  fire_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> !fire);

  // R5
  fire_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> (fieldEn != '0));
endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtcAlarmPkg::*;
(
  input  logic          regWr,
  input  logic          regRd,
  input  logic [AW-1:0] regAddr,
  output strobes_t      strb
);
  logic                 lowSpace;
  logic [FLD_IDX_W-1:0] fld;
  logic [ALM_IDX_W-1:0] alm;
  logic [AW-1:0]        hiOff;
  logic                 fieldHit;
  logic                 enHit;
  logic                 statHit;
  logic                 maskHit;

  always_comb begin
    lowSpace = !regAddr[AW-1];
    fld      = regAddr[FLD_IDX_W-1:0];
    alm      = regAddr[FLD_IDX_W +: ALM_IDX_W];
    hiOff    = regAddr - AW'(HIGH_BASE);
    fieldHit = lowSpace && (int'(fld) < FIELDS) && (int'(alm) < ALARMS);
    enHit    = !lowSpace && (int'(hiOff) < ALARMS);
    statHit  = !lowSpace && (int'(hiOff) == STAT_OFF);
    maskHit  = !lowSpace && (int'(hiOff) == MASK_OFF);
  end

  always_comb begin
    strb         = '0;
    strb.rdSel   = RD_NONE;
    strb.rdLoad  = regRd;
    strb.rdField = fld;
    strb.rdAlarm = enHit ? hiOff[ALM_IDX_W-1:0] : alm;
    if (regWr) begin
      for (int a = 0; a < ALARMS; a++) begin
        for (int f = 0; f < FIELDS; f++) begin
          strb.fieldWe[a][f] = fieldHit && (int'(alm) == a) && (int'(fld) == f);
        end
        strb.enWe[a] = enHit && (int'(hiOff) == a);
      end
      strb.maskWe = maskHit;
    end
    if (regRd) begin
      strb.statusRd = statHit;
      if (fieldHit)     strb.rdSel = RD_FIELD;
      else if (enHit)   strb.rdSel = RD_EN;
      else if (statHit) strb.rdSel = RD_STAT;
      else if (maskHit) strb.rdSel = RD_MASK;
    end
  end
endmodule

// File: rtl/rtc_alarm_datapath.sv
module rtc_alarm_datapath
  import rtcAlarmPkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  strobes_t                   strb,
  input  logic [FW-1:0]              wdata,
  input  logic                       sepEnMode,
  input  logic [FIELDS-1:0][FW-1:0]  cal,
  input  logic                       secTick,
  input  logic                       minTick,
  input  logic                       pwrEvtA,
  input  logic                       pwrEvtB,
  output logic [FW-1:0]              rdata,
  output logic                       irqN
);
  logic [ALARMS-1:0][FIELDS-1:0][FW-1:0] almQ;
  logic [ALARMS-1:0][FW-1:0]             enQ;
  logic [SRC_N-1:0]                      maskQ;
  logic [SRC_N-1:0]                      statusQ;
  logic [ALARMS-1:0]                     fireVec;
  logic [SRC_N-1:0]                      evt;
  logic [FW-1:0]                         rdNext;

  for (genvar a = 0; a < ALARMS; a++) begin : g_alm
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        almQ[a] <= '0;
        enQ[a]  <= '0;
      end else begin
        for (int f = 0; f < FIELDS; f++) begin
          if (strb.fieldWe[a][f]) almQ[a][f] <= wdata;
        end
        if (strb.enWe[a]) enQ[a] <= wdata;
      end
    end

    rtc_alarm_match u_match (
      .clk       (clk),
      .rstN      (rstN),
      .sepMode   (sepEnMode),
      .almFields (almQ[a]),
      .enReg     (enQ[a]),
      .cal       (cal),
      .fire      (fireVec[a])
    );

    // R7
    alarm_status_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      fireVec[a] |=> statusQ[a]);
  end

  assign evt = {pwrEvtB, pwrEvtA, minTick, secTick, fireVec};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ   <= '1;
      statusQ <= '0;
    end else begin
      if (strb.maskWe) maskQ <= wdata[SRC_N-1:0];
      statusQ <= (strb.statusRd ? '0 : statusQ) | evt;
    end
  end

  always_comb begin
    rdNext = '0;
    case (strb.rdSel)
      RD_FIELD: rdNext = almQ[strb.rdAlarm][strb.rdField];
      RD_EN:    rdNext = enQ[strb.rdAlarm];
      RD_STAT:  rdNext = FW'(statusQ);
      RD_MASK:  rdNext = FW'(maskQ);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdata <= '0;
    else if (strb.rdLoad) rdata <= rdNext;
  end

  assign irqN = ~|(statusQ & ~maskQ);

  // R9
  mask_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskWe |=> (maskQ == $past(wdata[SRC_N-1:0])));

  // R8
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statusRd && evt == '0) |=> (statusQ == '0));

  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ == '0) |-> irqN);
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
  import rtcAlarmPkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sepEnMode,
  input  logic [FIELDS-1:0][FW-1:0]  calFields,
  input  logic                       secTick,
  input  logic                       minTick,
  input  logic                       pwrEvtA,
  input  logic                       pwrEvtB,
  input  logic                       regWr,
  input  logic                       regRd,
  input  logic [AW-1:0]              regAddr,
  input  logic [FW-1:0]              regWdata,
  output logic [FW-1:0]              regRdata,
  output logic                       irqN
);
  strobes_t strb;

  rtc_alarm_ctrl u_ctrl (
    .regWr   (regWr),
    .regRd   (regRd),
    .regAddr (regAddr),
    .strb    (strb)
  );

  rtc_alarm_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wdata     (regWdata),
    .sepEnMode (sepEnMode),
    .cal       (calFields),
    .secTick   (secTick),
    .minTick   (minTick),
    .pwrEvtA   (pwrEvtA),
    .pwrEvtB   (pwrEvtB),
    .rdata     (regRdata),
    .irqN      (irqN)
  );
endmodule

// File: tb/rtc_alarm_top_bench.sv
module rtc_alarm_top_bench;
  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            sepEnMode = 1'b0;
  logic [6:0][7:0] cal = '0;
  logic            secTick = 1'b0, minTick = 1'b0, pwrEvtA = 1'b0, pwrEvtB = 1'b0;
  logic            regWr = 1'b0, regRd = 1'b0;
  logic [4:0]      regAddr = '0;
  logic [7:0]      regWdata = '0;
  logic [7:0]      regRdata;
  logic            irqN;

  int checks = 0;
  int fails  = 0;

  logic [7:0] mAlarm [2][7];
  logic [7:0] mEn [2];
  logic [5:0] mMask = 6'h3F;
  logic [5:0] mStat = '0;
  logic       mPrev [2];
  logic [7:0] mRd = '0;

  always #2ns clk = ~clk;

  rtc_alarm_top u_rtc_alarm_top (
    .clk(clk), .rstN(rstN), .sepEnMode(sepEnMode), .calFields(cal),
    .secTick(secTick), .minTick(minTick), .pwrEvtA(pwrEvtA), .pwrEvtB(pwrEvtB),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqN(irqN)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic mMatch(input int a);
    logic any = 1'b0;
    logic all = 1'b1;
    for (int i = 0; i < 7; i++) begin
      logic en;
      logic eq;
      if (i == 3) en = 1'b0;
      else        en = sepEnMode ? mEn[a][i] : mAlarm[a][i][7];
      eq = sepEnMode ? (mAlarm[a][i] == cal[i]) : ({1'b0, mAlarm[a][i][6:0]} == cal[i]);
      if (en) begin
        any = 1'b1;
        if (!eq) all = 1'b0;
      end
    end
    return any && all;
  endfunction

  function automatic logic [7:0] mRead(input logic [4:0] a);
    if (!a[4]) return (a[2:0] < 3'd7) ? mAlarm[a[3]][a[2:0]] : 8'h00;
    case (a)
      5'h10: return mEn[0];
      5'h11: return mEn[1];
      5'h12: return {2'b00, mStat};
      5'h13: return {2'b00, mMask};
      default: return 8'h00;
    endcase
  endfunction

  // Drives one cycle at a falling edge, models the rising edge, checks at the next falling edge
  task automatic step(input string tag, input logic wr, input logic rd,
                      input logic [4:0] a, input logic [7:0] d, input logic [3:0] ev);
    logic [1:0] fire;
    regWr = wr; regRd = rd; regAddr = a; regWdata = d;
    {pwrEvtB, pwrEvtA, minTick, secTick} = ev;
    for (int k = 0; k < 2; k++) begin
      logic m;
      m = mMatch(k);
      fire[k] = m && !mPrev[k];
      mPrev[k] = m;
    end
    if (rd) mRd = mRead(a);
    if (rd && a == 5'h12) mStat = '0;
    mStat = mStat | {ev, fire};
    if (wr) begin
      if (!a[4] && a[2:0] < 3'd7) mAlarm[a[3]][a[2:0]] = d;
      else if (a == 5'h10) mEn[0] = d;
      else if (a == 5'h11) mEn[1] = d;
      else if (a == 5'h13) mMask = d[5:0];
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " irqN"}, {7'b0, irqN}, {7'b0, ~|(mStat & ~mMask)});
    if (rd) check({tag, " rdata"}, regRdata, mRd);
  endtask

  task automatic wr(input string tag, input logic [4:0] a, input logic [7:0] d);
    step(tag, 1'b1, 1'b0, a, d, 4'b0);
  endtask
  task automatic rd(input string tag, input logic [4:0] a);
    step(tag, 1'b0, 1'b1, a, 8'h00, 4'b0);
  endtask
  task automatic idle(input string tag);
    step(tag, 1'b0, 1'b0, 5'h00, 8'h00, 4'b0);
  endtask

  task automatic setCal(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                        input logic [7:0] w, input logic [7:0] mo, input logic [7:0] y,
                        input logic [7:0] dt);
    cal = {dt, y, mo, w, h, mi, s};
  endtask

  initial begin
    #(4ns * 150000);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_A1A7));
    for (int a = 0; a < 2; a++) begin
      mEn[a] = '0; mPrev[a] = 1'b0;
      for (int f = 0; f < 7; f++) mAlarm[a][f] = '0;
    end
    setCal(8'd9, 8'd20, 8'd5, 8'h04, 8'd3, 8'd24, 8'd15);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 irqN after reset", {7'b0, irqN}, 8'h01);
    check("R10 rdata after reset", regRdata, 8'h00);
    rd("R10 status reset", 5'h12);
    rd("R9 mask reset", 5'h13);
    rd("R10 field reset", 5'h06);
    rd("R10 enable reset", 5'h11);

    // R1 map and readback
    wr("R1 write a0 year", 5'h05, 8'hA5);
    rd("R1 read a0 year", 5'h05);
    wr("R1 write a1 month", 5'h0C, 8'h3C);
    rd("R1 read a1 month", 5'h0C);
    wr("R1 write unmapped", 5'h07, 8'hFF);
    rd("R1 read unmapped", 5'h07);
    wr("R1 write status ignored", 5'h12, 8'hFF);
    rd("R1 status after write", 5'h12);
    idle("R1 read data holds");
    check("R1 rdata holds", regRdata, 8'h00);

    wr("R9 unmask all", 5'h13, 8'h00);

    // R2 flag mode, R3 weekday flag set with mismatching value
    sepEnMode = 1'b0;
    wr("R2 sec", 5'h00, 8'h80 | 8'd10);
    wr("R2 min", 5'h01, 8'h80 | 8'd20);
    wr("R2 hour", 5'h02, 8'h80 | 8'd5);
    wr("R3 weekday flagged", 5'h03, 8'h81);
    wr("R2 month", 5'h04, 8'h80 | 8'd3);
    wr("R2 year disabled", 5'h05, 8'h00);
    wr("R2 date", 5'h06, 8'h80 | 8'd15);
    idle("R2 no match yet");
    rd("R2 status clear before", 5'h12);
    cal[0] = 8'd10;
    idle("R2 R3 fire on match");
    check("R2 irq low on fire", {7'b0, irqN}, 8'h00);
    rd("R2 status alarm0", 5'h12);
    check("R3 alarm0 bit set", regRdata & 8'h01, 8'h01);
    repeat (5) idle("R6 hold match");
    rd("R6 no refire", 5'h12);
    check("R6 no refire status", regRdata, 8'h00);
    cal[0] = 8'd11; idle("R6 break match");
    cal[0] = 8'd10; idle("R6 rematch");
    rd("R6 refire status", 5'h12);
    check("R6 refire bit", regRdata, 8'h01);

    // R5 clear all flags while matching
    for (int f = 0; f < 7; f++) wr("R5 clear flag", 5'(f), 8'h7F & mAlarm[0][f]);
    cal[0] = 8'd11; idle("R5 toggle");
    cal[0] = 8'd10; idle("R5 toggle back");
    rd("R5 no fire without enables", 5'h12);
    check("R5 status zero", regRdata, 8'h00);

    // R4 separate-enable mode, full byte compare on alarm 1
    sepEnMode = 1'b1;
    cal[5] = 8'h98;
    for (int f = 0; f < 7; f++) wr("R4 program a1", 5'(8 + f), (f == 3) ? 8'h02 : cal[f]);
    wr("R4 enable 0x77", 5'h11, 8'h77);
    idle("R4 fire");
    rd("R4 status alarm1", 5'h12);
    check("R4 alarm1 bit", regRdata, 8'h02);
    wr("R5 enable zero", 5'h11, 8'h00);
    cal[0] = 8'd12; idle("R5 sep break");
    cal[0] = 8'd10; idle("R5 sep rematch");
    rd("R5 sep no fire", 5'h12);
    check("R5 sep status zero", regRdata, 8'h00);
    wr("R3 weekday only", 5'h11, 8'h08);
    cal[0] = 8'd12; idle("R3 break");
    cal[0] = 8'd10; idle("R3 rematch");
    rd("R3 weekday only no fire", 5'h12);
    check("R3 status zero", regRdata, 8'h00);

    // R9 masked source
    wr("R9 mask sec tick", 5'h13, 8'h04);
    step("R9 sec tick masked", 1'b0, 1'b0, 5'h00, 8'h00, 4'b0001);
    check("R9 irq stays high", {7'b0, irqN}, 8'h01);
    rd("R9 masked bit still set", 5'h12);
    check("R7 sec tick bit", regRdata, 8'h04);

    // R8 event during clearing read
    step("R8 read with min tick", 1'b0, 1'b1, 5'h12, 8'h00, 4'b0010);
    rd("R8 event kept", 5'h12);
    check("R8 min tick survives", regRdata, 8'h08);
    step("R7 pwr events", 1'b0, 1'b0, 5'h00, 8'h00, 4'b1100);
    rd("R7 pwr bits", 5'h12);

    // Random phase
    for (int n = 0; n < 6000; n++) begin
      int r;
      logic [3:0] ev;
      if ($urandom % 2 == 0) begin
        int f;
        f = $urandom % 7;
        case (f)
          0: cal[0] = 8'($urandom % 4);
          3: cal[3] = 8'(1 << ($urandom % 7));
          5: cal[5] = ($urandom % 2 == 0) ? 8'h00 : 8'h98;
          default: cal[f] = 8'($urandom % 2 + 1);
        endcase
      end
      if ($urandom % 300 == 0) sepEnMode = ~sepEnMode;
      ev = 4'($urandom % 16) & 4'($urandom % 16) & 4'($urandom % 16);
      r = $urandom % 20;
      if (r < 3) begin
        int a;
        int f;
        logic [7:0] v;
        a = $urandom % 2; f = $urandom % 7;
        v = (f == 0) ? 8'($urandom % 4) : (f == 5) ? (($urandom % 2 == 0) ? 8'h00 : 8'h98)
                                          : 8'($urandom % 2 + 1);
        if (f != 5 && $urandom % 3 != 0) v = v | 8'h80;
        step("R2 R4 R6 random field write", 1'b1, 1'b0, 5'(a * 8 + f), v, ev);
      end else if (r == 3) begin
        step("R4 R5 random enable write", 1'b1, 1'b0, 5'(16 + $urandom % 2),
             ($urandom % 2 == 0) ? 8'h77 : 8'($urandom), ev);
      end else if (r == 4) begin
        step("R9 random mask write", 1'b1, 1'b0, 5'h13, 8'($urandom), ev);
      end else if (r < 8) begin
        step("R7 R8 random status read", 1'b0, 1'b1, 5'h12, 8'h00, ev);
      end else if (r == 8) begin
        step("R1 random read", 1'b0, 1'b1, 5'($urandom), 8'h00, ev);
      end else begin
        step("R6 R9 random idle", 1'b0, 1'b0, 5'h00, 8'h00, ev);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule